// File: doc/BRIEF.md
# Serial Flash Hold-Pause Gate

This block sits on the device side of a serial flash port. It lets the host pause a transaction that is already running without deselecting the device. It watches chip select, the serial clock and an active-low hold pin. From these it makes a hold flag that does three things: it freezes the receive and transmit shift registers and their bit counter, it turns off the serial data output enable, and it makes the block ignore clock edges and data-input bits. The flag changes only while the serial clock is low, so a hold never splits a bit. When the hold is released, the transfer resumes at the same bit position.

All inputs are sampled on a faster system clock. They are expected to be synchronised already. Serial clock edges are found by comparing each sample of the serial clock with the previous one. An enable input switches the hold feature on, and it is off unless driven high. A quad-transfer input turns hold detection off while the hold pin is carrying data. Data moves in mode 0 style: bits are captured on rising serial clock edges and the output shifts on falling edges, most significant bit first.

Top module: `spi_hold_gate`

## Requirements
- R1: While `cs_ni` is high, `hold_o` stays 0 whatever `hold_ni` does.
- R2: When the device is selected and hold is enabled, a low on `hold_ni` while `sck_i` is low raises `hold_o` one system clock later.
- R3: If `hold_ni` falls while `sck_i` is high, `hold_o` stays 0 until `sck_i` goes low, and rises one system clock after that.
- R4: Hold ends one system clock after `hold_ni` returns high if `sck_i` is low. If `sck_i` is high at that time, hold ends one system clock after the next low on `sck_i`.
- R5: While `hold_o` is 1, `so_oe_o` is 0 and `so_o` does not change.
- R6: While hold is active, rising `sck_i` edges and `si_i` are ignored. The bit counter and both shift registers keep their values, and the byte completes correctly once hold is released.
- R7: With `hold_en_i` low, `hold_ni` has no effect on `hold_o` or `so_oe_o`.
- R8: With `quad_i` high, a low on `hold_ni` does not start a hold.
- R9: A high on `cs_ni` clears an active or pending hold on the next system clock. Reset leaves `hold_o`, `so_oe_o` and `rx_valid_o` at 0.
- R10: Every DATA_W rising `sck_i` edges outside hold assemble one byte from `si_i`, first bit into the MSB. That byte appears on `rx_data_o`, and `rx_valid_o` pulses for one system clock.
- R11: `so_o` presents `tx_data_i` MSB first. The first bit is driven before the first rising edge, and each following falling edge shifts. `tx_data_i` is reloaded whenever `cs_ni` is high and at each byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_en_i | input | 1 | Enables the hold feature |
| quad_i | input | 1 | Quad transfer in progress; hold detection suppressed |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock (synchronised) |
| hold_ni | input | 1 | Hold request, active low |
| si_i | input | 1 | Serial data in |
| tx_data_i | input | DATA_W | Next byte to transmit |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |
| hold_o | output | 1 | Hold active |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle pulse when rx_data_o updates |

## Verification
The assertions check the following on every cycle:
- `hold_o` never changes while the sampled serial clock is high.
- Chip select high, a disabled feature and quad mode each keep `hold_o` low.
- A hold blocks the next byte-complete pulse.
- The output stays frozen and tri-stated while the hold lasts.

Some properties are only shown by the bench's scenarios:
- The single-cycle entry and exit latency.
- A byte split by a hold, with clock toggling and noise on the data input, reassembling to the right value.
- The transmit stream continuing at the right bit.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_edge_t;
endpackage

// File: rtl/spi_hold_edge.sv
module spi_hold_edge
  import spi_hold_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sck_i,
  output sck_edge_t edge_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign edge_o.rise = sck_i & ~sck_q;
  assign edge_o.fall = ~sck_i & sck_q;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_en_i,
  input  logic quad_i,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic hold_o
);
  logic req;
  logic hold_q;

  assign req = hold_en_i & ~quad_i & ~hold_ni;

  // state may only move while sck is low: a high clock defers entry/exit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= 1'b0;
    else if (cs_ni)  hold_q <= 1'b0;
    else if (!sck_i) hold_q <= req;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift
  import spi_hold_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              hold_i,
  input  sck_edge_t         edge_i,
  input  logic              si_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              so_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_next;
  logic              step_in;
  logic              step_out;

  assign step_in  = edge_i.rise & ~hold_i;
  // no shift on the fall right after a byte reload
  assign step_out = edge_i.fall & ~hold_i & (bit_cnt != '0);
  assign rx_next  = {rx_sr[DATA_W-2:0], si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (cs_ni) begin
        bit_cnt <= '0;
        tx_sr   <= tx_data_i;
      end else if (step_in) begin
        rx_sr <= rx_next;
        if (bit_cnt == LAST) begin
          bit_cnt    <= '0;
          rx_data_o  <= rx_next;
          rx_valid_o <= 1'b1;
          tx_sr      <= tx_data_i;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (step_out) begin
        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign so_o = tx_sr[DATA_W-1];
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_en_i,
  input  logic              quad_i,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              hold_ni,
  input  logic              si_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              hold_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  sck_edge_t sck_edge;
  logic      hold;

  spi_hold_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .edge_o (sck_edge)
  );

  spi_hold_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_en_i (hold_en_i),
    .quad_i    (quad_i),
    .cs_ni     (cs_ni),
    .sck_i     (sck_i),
    .hold_ni   (hold_ni),
    .hold_o    (hold)
  );

  spi_hold_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .hold_i     (hold),
    .edge_i     (sck_edge),
    .si_i       (si_i),
    .tx_data_i  (tx_data_i),
    .so_o       (so_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );

  assign so_oe_o = ~cs_ni & ~hold;
  assign hold_o  = hold;
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hold_en_i,
  input logic quad_i,
  input logic cs_ni,
  input logic sck_i,
  input logic hold_o,
  input logic so_o,
  input logic so_oe_o,
  input logic rx_valid_o
);
  p_unselected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !hold_o) |=> !hold_o);

  // R2, R3, R4: hold flag only moves on cycles sampled with sck low (or on deselect)
  p_sck_low_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o != $past(hold_o)) |-> (!$past(sck_i) || $past(cs_ni)));

  p_oe_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !so_oe_o);

  p_so_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && $past(hold_o)) |-> $stable(so_o));

  p_no_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> !rx_valid_o);

  p_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_en_i && !hold_o) |=> !hold_o);

  p_quad_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_i && !hold_o) |=> !hold_o);

  p_cs_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !hold_o);
endmodule

bind spi_hold_gate spi_hold_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_en_i  (hold_en_i),
  .quad_i     (quad_i),
  .cs_ni      (cs_ni),
  .sck_i      (sck_i),
  .hold_o     (hold_o),
  .so_o       (so_o),
  .so_oe_o    (so_oe_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/spi_hold_gate_tb_top.sv
module spi_hold_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hold_en = 1'b0, quad = 1'b0, cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         so, so_oe, hold, rx_valid;
  logic [W-1:0] rx_data;

  int n_chk = 0, n_fail = 0, valid_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hold_gate #(.DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hold_en_i(hold_en), .quad_i(quad), .cs_ni(cs_n),
    .sck_i(sck), .hold_ni(hold_n), .si_i(si), .tx_data_i(tx_data),
    .so_o(so), .so_oe_o(so_oe), .hold_o(hold), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one serial bit: returns so as seen just before the rising edge
  task automatic sck_bit(input logic b, output logic so_seen);
    si = b;
    tick(2);
    so_seen = so;
    sck = 1'b1;
    tick(1);
    if (rx_valid) valid_cnt++;
    tick(1);
    sck = 1'b0;
    tick(2);
  endtask

  task automatic select_with(input logic [W-1:0] tx);
    cs_n = 1'b1; sck = 1'b0; tx_data = tx;
    tick(2);
    cs_n = 1'b0;
    tick(2);
  endtask

  task automatic t_reset;
    chk("R9 reset hold", hold, 0);
    chk("R9 reset oe", so_oe, 0);
    chk("R9 reset valid", rx_valid, 0);
  endtask

  task automatic t_disabled;
    hold_en = 1'b0; cs_n = 1'b0; sck = 1'b0; hold_n = 1'b0;
    tick(3);
    chk("R7 disabled hold", hold, 0);
    chk("R7 disabled oe", so_oe, 1);
    hold_n = 1'b1; cs_n = 1'b1;
    tick(2);
  endtask

  task automatic t_unselected;
    hold_en = 1'b1; cs_n = 1'b1; hold_n = 1'b0;
    tick(3);
    chk("R1 unselected", hold, 0);
    cs_n = 1'b0;
    tick(1);
    chk("R2 selected with hold low", hold, 1);
    cs_n = 1'b1;
    tick(1);
    chk("R9 deselect clears", hold, 0);
    hold_n = 1'b1;
    tick(2);
  endtask

  task automatic t_entry_low;
    cs_n = 1'b0; sck = 1'b0;
    tick(2);
    hold_n = 1'b0;
    tick(1);
    chk("R2 entry sck low", hold, 1);
    chk("R5 oe off", so_oe, 0);
    hold_n = 1'b1;
    tick(1);
    chk("R4 exit sck low", hold, 0);
    chk("R5 oe back", so_oe, 1);
  endtask

  task automatic t_deferred;
    sck = 1'b1;
    tick(2);
    hold_n = 1'b0;
    tick(3);
    chk("R3 entry deferred", hold, 0);
    sck = 1'b0;
    tick(1);
    chk("R3 entry at sck fall", hold, 1);
    sck = 1'b1;
    tick(1);
    hold_n = 1'b1;
    tick(3);
    chk("R4 exit deferred", hold, 1);
    sck = 1'b0;
    tick(1);
    chk("R4 exit at sck fall", hold, 0);
  endtask

  task automatic t_quad;
    quad = 1'b1; hold_n = 1'b0;
    tick(3);
    chk("R8 quad hold", hold, 0);
    chk("R8 quad oe", so_oe, 1);
    quad = 1'b0;
    tick(1);
    chk("R8 quad released", hold, 1);
    hold_n = 1'b1; cs_n = 1'b1;
    tick(2);
  endtask

  task automatic t_byte;
    logic [W-1:0] so_got;
    logic [W-1:0] pat;
    logic b;
    pat = 8'hA5;
    valid_cnt = 0;
    select_with(8'h3C);
    for (int i = W - 1; i >= 0; i--) begin
      sck_bit(pat[i], b);
      so_got[i] = b;
    end
    chk("R10 rx byte", rx_data, 32'hA5);
    chk("R10 valid pulses", valid_cnt, 1);
    chk("R11 so stream", so_got, 32'h3C);
  endtask

  task automatic t_hold_resume;
    logic [W-1:0] so_got;
    logic [W-1:0] pat;
    logic b, so_held;
    pat = 8'h5A;
    valid_cnt = 0;
    select_with(8'hC3);
    for (int i = W - 1; i >= 4; i--) begin
      sck_bit(pat[i], b);
      so_got[i] = b;
    end
    hold_n = 1'b0;
    tick(1);
    chk("R5 oe off mid byte", so_oe, 0);
    so_held = so;
    for (int k = 0; k < 5; k++) sck_bit(k[0], b);
    chk("R6 no capture in hold", valid_cnt, 0);
    chk("R5 so frozen", so, so_held);
    hold_n = 1'b1;
    tick(1);
    chk("R4 released", hold, 0);
    for (int i = 3; i >= 0; i--) begin
      sck_bit(pat[i], b);
      so_got[i] = b;
    end
    chk("R6 byte resumed", rx_data, 32'h5A);
    chk("R6 single pulse", valid_cnt, 1);
    chk("R11 so resumed", so_got, 32'hC3);
    cs_n = 1'b1;
    tick(2);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_disabled();
    t_unselected();
    t_entry_low();
    t_deferred();
    t_quad();
    t_byte();
    t_hold_resume();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule